// File: doc/BRIEF.md
# Bank row-cycle and refresh scheduler

This block decides which command goes to an eight-bank DRAM on each clock. A requester presents a read or write tagged with a bank number. The scheduler accepts it only when that bank has finished its previous row cycle. Each bank keeps its own countdown, so banks can be used in any order, and a round-robin walk over the banks sustains one command per clock.

The scheduler also issues auto-refresh on its own. A free-running interval counter raises a refresh request at a fixed period. That period is derived from the retention window, the refreshes each bank needs in that window and the number of banks. Refreshes walk the banks in ascending order and carry only a bank number, because the memory keeps its own row pointer. A refresh occupies its bank for a full row cycle, the same as any other command. At most one command, user or refresh, leaves the block per clock.

Top module: `bank_rc_sched`

## Requirements
- R1: While reset is asserted and on the first edge after it, no command is issued (`cmd_valid` low).
- R2: A request to a bank whose row cycle has expired, with no refresh eligible, is accepted in the same cycle (`req_ready` high). On the next clock edge `cmd_valid` rises with `cmd_refresh` low and with the requested bank and write flag. `req_ready` is never high without `req_valid`.
- R3: After a command to a bank, granted while `rc_len` held N, no further command to that bank appears until N clock edges later. An `rc_len` of 0 behaves as 1.
- R4: Commands to different banks may be issued on consecutive clock edges.
- R5: With `rc_len` = 1 the same bank may be accepted on every cycle.
- R6: A refresh command has `cmd_refresh` high and `cmd_write` low. Successive refreshes name banks 0, 1, ..., 7 and then wrap to 0.
- R7: When a refresh is pending and its bank's row cycle has expired, the refresh takes the cycle. A user request presented in that cycle is held off (`req_ready` low).
- R8: A pending refresh whose bank is still in its row cycle waits until the cycle expires. Requests to other free banks are accepted in the meantime.
- R9: The refresh period is `RETENTION_CYCLES / (REFS_PER_BANK * NUM_BANKS)` clocks, counted from reset release. With no user traffic, the k-th refresh (k from 1) appears on edge k*period + 1 after reset release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rc_len | input | RC_W | Row-cycle length in clocks, sampled when a command is granted |
| req_valid | input | 1 | User request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bank | input | BANK_W | Target bank of the request |
| req_ready | output | 1 | Request accepted this cycle |
| cmd_valid | output | 1 | A command is issued this cycle |
| cmd_refresh | output | 1 | The issued command is an auto-refresh |
| cmd_write | output | 1 | The issued command is a write |
| cmd_bank | output | BANK_W | Bank of the issued command |

## Verification
The two functions that can collide are the refresh generator and user arbitration: a refresh can become pending in the very cycle a user request is waiting. The collision is provoked by streaming requests to one bank with a one-clock row cycle across several refresh ticks, so that the refresh must win at exactly the predicted cycle. A second directed case occupies the bank next in refresh order just before a tick; the refresh must then slip by a computed number of edges while another bank's request goes through. Random traffic with changing row-cycle lengths is then judged for spacing, ordering and refresh rate.

// File: rtl/bank_rc_sched.sv
module bank_rc_sched #(
  parameter int NUM_BANKS        = 8,
  parameter int RC_W             = 4,
  parameter int RETENTION_CYCLES = 6400000,
  parameter int REFS_PER_BANK    = 8192
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [RC_W-1:0]              rc_len,
  input  logic                         req_valid,
  input  logic                         req_write,
  input  logic [$clog2(NUM_BANKS)-1:0] req_bank,
  output logic                         req_ready,
  output logic                         cmd_valid,
  output logic                         cmd_refresh,
  output logic                         cmd_write,
  output logic [$clog2(NUM_BANKS)-1:0] cmd_bank
);
  localparam int BANK_W  = $clog2(NUM_BANKS);
  localparam int REF_GAP = RETENTION_CYCLES / (REFS_PER_BANK * NUM_BANKS);
  localparam int GAP_W   = $clog2(REF_GAP + 1);

  logic [RC_W-1:0]      rc_cnt [NUM_BANKS];
  logic [NUM_BANKS-1:0] busy;
  logic [GAP_W-1:0]     gap_cnt;
  logic                 ref_pend;
  logic [BANK_W-1:0]    ref_ptr;

  logic              gap_tick, ref_go, user_go, grant_any;
  logic [BANK_W-1:0] grant_bank;
  logic [RC_W-1:0]   rc_load;

  assign gap_tick   = (gap_cnt == GAP_W'(REF_GAP - 1));
  assign ref_go     = ref_pend && !busy[ref_ptr];
  assign user_go    = req_valid && !busy[req_bank] && !ref_go;
  assign req_ready  = user_go;
  assign grant_any  = ref_go || user_go;
  assign grant_bank = ref_go ? ref_ptr : req_bank;
  assign rc_load    = (rc_len == '0) ? '0 : rc_len - 1'b1;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        rc_cnt[b] <= '0;
      else if (grant_any && grant_bank == BANK_W'(b))
        rc_cnt[b] <= rc_load;
      else if (rc_cnt[b] != '0)
        rc_cnt[b] <= rc_cnt[b] - 1'b1;
    end
    assign busy[b] = (rc_cnt[b] != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_cnt  <= '0;
      ref_pend <= 1'b0;
      ref_ptr  <= '0;
    end else begin
      gap_cnt  <= gap_tick ? '0 : gap_cnt + 1'b1;
      ref_pend <= (ref_pend && !ref_go) || gap_tick;
      if (ref_go)
        ref_ptr <= (ref_ptr == BANK_W'(NUM_BANKS - 1)) ? '0 : ref_ptr + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_valid   <= 1'b0;
      cmd_refresh <= 1'b0;
      cmd_write   <= 1'b0;
      cmd_bank    <= '0;
    end else begin
      cmd_valid   <= grant_any;
      cmd_refresh <= ref_go;
      cmd_write   <= user_go && req_write;
      cmd_bank    <= grant_bank;
    end
  end
endmodule

// File: rtl/bank_rc_sched_chk.sv
module bank_rc_sched_chk #(
  parameter int NUM_BANKS = 8,
  parameter int RC_W      = 4
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic [RC_W-1:0]              rc_len,
  input logic                         req_valid,
  input logic                         req_write,
  input logic [$clog2(NUM_BANKS)-1:0] req_bank,
  input logic                         req_ready,
  input logic                         cmd_valid,
  input logic                         cmd_refresh,
  input logic                         cmd_write,
  input logic [$clog2(NUM_BANKS)-1:0] cmd_bank
);
  localparam int BANK_W = $clog2(NUM_BANKS);

  logic [RC_W-1:0] rc_q;
  logic [RC_W:0]   age  [NUM_BANKS];
  logic [RC_W:0]   need [NUM_BANKS];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) rc_q <= '0;
    else        rc_q <= rc_len;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_age
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        age[b]  <= '1;
        need[b] <= '0;
      end else if (cmd_valid && cmd_bank == BANK_W'(b)) begin
        age[b]  <= (RC_W+1)'(1);
        need[b] <= (rc_q == '0) ? (RC_W+1)'(1) : {1'b0, rc_q};
      end else if (age[b] != '1) begin
        age[b]  <= age[b] + 1'b1;
      end
    end
  end

  a_r2_ready_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> req_valid);

  a_r2_accept_issues: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> cmd_valid && !cmd_refresh && cmd_bank == $past(req_bank)
                               && cmd_write == $past(req_write));

  a_r3_row_cycle_kept: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> age[cmd_bank] >= need[cmd_bank]);

  a_r6_refresh_reads_nothing: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_refresh |-> !cmd_write);

  a_r7_refresh_displaces_user: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> !(cmd_valid && !cmd_refresh));

  a_r1_flags_need_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |-> !cmd_refresh && !cmd_write);
endmodule

bind bank_rc_sched bank_rc_sched_chk #(.NUM_BANKS(NUM_BANKS), .RC_W(RC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rc_len(rc_len), .req_valid(req_valid),
  .req_write(req_write), .req_bank(req_bank), .req_ready(req_ready),
  .cmd_valid(cmd_valid), .cmd_refresh(cmd_refresh), .cmd_write(cmd_write),
  .cmd_bank(cmd_bank));

// File: tb/bank_rc_sched_bench.sv
module bank_rc_sched_bench;
  localparam int NB   = 8;
  localparam int RETN = 3200;
  localparam int RPB  = 8;
  localparam int GAP  = RETN / (RPB * NB);

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] rc_len = 4'd4;
  logic       req_valid = 1'b0;
  logic       req_write = 1'b0;
  logic [2:0] req_bank = 3'd0;
  logic       req_ready, cmd_valid, cmd_refresh, cmd_write;
  logic [2:0] cmd_bank;

  bank_rc_sched #(.NUM_BANKS(NB), .RC_W(4), .RETENTION_CYCLES(RETN), .REFS_PER_BANK(RPB))
    u_bank_rc_sched (.clk(clk), .rst_n(rst_n), .rc_len(rc_len), .req_valid(req_valid),
      .req_write(req_write), .req_bank(req_bank), .req_ready(req_ready),
      .cmd_valid(cmd_valid), .cmd_refresh(cmd_refresh), .cmd_write(cmd_write),
      .cmd_bank(cmd_bank));

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0, e = 0;
  int last_edge [NB];
  int last_rc [NB];
  int ref_ptr_exp = 0, nref = 0, last_ref_edge = 0;
  bit exp_user = 0, exp_write = 0, live_pend = 0, timing_on = 0, rdy = 0, done = 0;
  int exp_bank = 0, grant_rc = 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at edge %0d: actual=%0d expected=%0d", req, e, act, exp);
    end
  endtask

  function automatic bit bank_free(input int b);
    return (e + 1 - last_edge[b]) >= last_rc[b];
  endfunction

  task automatic observe();
    if (live_pend)
      chk(cmd_valid && cmd_refresh, "R7 held request must yield to refresh", int'(cmd_refresh), 1);
    if (exp_user) begin
      chk(cmd_valid && !cmd_refresh, "R2 accepted request issued", int'(cmd_valid), 1);
      chk(int'(cmd_bank) == exp_bank, "R2 bank", int'(cmd_bank), exp_bank);
      chk(cmd_write == exp_write, "R2 write flag", int'(cmd_write), int'(exp_write));
    end else if (cmd_valid) begin
      chk(cmd_refresh, "R6 unrequested command is refresh", int'(cmd_refresh), 1);
      chk(int'(cmd_bank) == ref_ptr_exp, "R6 refresh order", int'(cmd_bank), ref_ptr_exp);
      chk(!cmd_write, "R6 refresh not write", int'(cmd_write), 0);
      if (timing_on && nref < 3)
        chk(e == GAP * (nref + 1) + 1, "R9 refresh period", e, GAP * (nref + 1) + 1);
      ref_ptr_exp = (ref_ptr_exp + 1) % NB;
      nref++;
      last_ref_edge = e;
    end
    if (cmd_valid) begin
      chk(e - last_edge[cmd_bank] >= last_rc[cmd_bank], "R3 row-cycle spacing",
          e - last_edge[cmd_bank], last_rc[cmd_bank]);
      last_edge[cmd_bank] = e;
      last_rc[cmd_bank]   = grant_rc;
    end
    exp_user = 0;
  endtask

  task automatic step(input bit v, input int b, input bit w, input int rc);
    @(posedge clk);
    e++;
    #1;
    observe();
    req_valid = v;
    req_bank  = 3'(b);
    req_write = w;
    rc_len    = 4'(rc);
    #1;
    rdy      = req_ready;
    grant_rc = (rc == 0) ? 1 : rc;
    if (rdy) begin
      chk(v, "R2 ready only with valid", 0, 1);
      chk(bank_free(b), "R3 accepted during row cycle", 0, 1);
      exp_user  = 1;
      exp_bank  = b;
      exp_write = w;
    end
    live_pend = v && bank_free(b) && !rdy;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired: actual=0 expected=1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NB; i++) begin
      last_edge[i] = -100;
      last_rc[i]   = 1;
    end
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    #1 chk(!cmd_valid, "R1 quiet in reset", int'(cmd_valid), 0);
    @(negedge clk) rst_n = 1'b1;

    // R1 + R9: idle, refreshes land on exact edges
    timing_on = 1;
    step(0, 0, 0, 4);
    chk(!cmd_valid, "R1 first edge quiet", int'(cmd_valid), 0);
    while (e < 3 * GAP + 5) step(0, 0, 0, 4);
    timing_on = 0;
    chk(nref == 3, "R9 refresh count idle", nref, 3);

    // R5 + R7: stream to bank 5 with one-clock row cycle
    for (int i = 0; i < 2 * GAP; i++) begin
      step(1, 5, 1, 1);
      chk(rdy == (e % GAP != 0), "R5/R7 ready pattern", int'(rdy), int'(e % GAP != 0));
    end

    // R4: consecutive different banks
    step(1, 1, 0, 4);
    chk(rdy, "R4 bank 1 accepted", int'(rdy), 1);
    step(1, 2, 1, 4);
    chk(rdy, "R4 bank 2 accepted next cycle", int'(rdy), 1);
    step(1, 2, 1, 4);
    chk(!rdy, "R3 bank 2 repeat held", int'(rdy), 0);
    step(0, 0, 0, 4);

    // R8: refresh bank busy at tick
    while (e % GAP != GAP - 3) step(0, 0, 0, 6);
    begin
      int busy_bank, other, m0, n0;
      busy_bank = ref_ptr_exp;
      other = (busy_bank + 3) % NB;
      step(1, busy_bank, 1, 6);
      chk(rdy, "R2 occupy next refresh bank", int'(rdy), 1);
      while (e % GAP != GAP - 1) step(0, 0, 0, 6);
      step(1, other, 0, 6);
      m0 = e;
      chk(rdy, "R8 other bank proceeds while refresh waits", int'(rdy), 1);
      n0 = nref;
      while (nref == n0 && e < m0 + 20) step(0, 0, 0, 6);
      chk(last_ref_edge == m0 + 5, "R8 refresh delayed to row-cycle end", last_ref_edge, m0 + 5);
    end

    // random traffic
    begin
      bit hv = 0, hw = 0;
      int hb = 0, rc = 3, start_e, start_n, span;
      start_e = e;
      start_n = nref;
      for (int i = 0; i < 4000; i++) begin
        if (i % 64 == 0) rc = int'($urandom_range(0, 6));
        if (!hv) begin
          hv = ($urandom_range(0, 9) < 7);
          hb = int'($urandom_range(0, NB - 1));
          hw = 1'($urandom_range(0, 1));
        end
        step(hv, hb, hw, rc);
        if (rdy) hv = 0;
      end
      span = e - start_e;
      chk(nref - start_n >= span / GAP - 1 && nref - start_n <= span / GAP + 1,
          "R9 refresh rate under load", nref - start_n, span / GAP);
    end

    step(0, 0, 0, 4);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule